// File: doc/BRIEF.md
# I2C Bus Condition Generator with Repeated-Start Support

This block creates the start and repeated-start conditions of a multi-master I2C controller under control of two host-writable byte registers: an address shift register and a control/status register. The host loads a target address into the shift register. It then writes the control register with its upper four bits all set. On a quiet bus this yields a start condition. If the bus is already owned and a transfer is pending, the same write yields a repeated start. In both cases the address byte follows, most significant bit first.

The block watches the bus lines through synchronisers and keeps a bus-busy flag that follows every start and stop on the wire, whoever drives it. After the address byte the block parks with both lines pulled low and flags a pending transfer. The host then lets go of the lines in a fixed order: clearing the transmit bit frees SDA, and loading the shift register frees SCL. Byte transfers after the address, arbitration recovery, clock division and interrupts lie outside this block.

Top module: `i2cg_ctrl`

## Requirements
- R1: After reset the status byte reads 0x10 (only the pending bit, bit 4, at 1, where 1 means no transfer pending) and neither line enable is active. The status layout is bit 7 master, bit 6 transmit, bit 5 bus-busy, bit 4 pending, bits 3..0 read 0.
- R2: Bus-busy (status bit 5) becomes 1 a few cycles after SDA falls while SCL is high, and becomes 0 after SDA rises while SCL is high, including conditions driven by another master.
- R3: Writes to status bit 5 have no effect; the bit shows only the observed bus state.
- R4: With bus-busy 0 and an address loaded, a status write whose upper nibble is 0xF pulls SDA low while SCL stays high for at least HOLD cycles, then clocks out the 8 address bits MSB first, each valid while SCL is high.
- R5: After the eighth bit both SCL and SDA stay pulled low, and the status reads 0xE0 (master, transmit, busy set, pending 0).
- R6: A trigger write while bus-busy is 1 and pending is 1, or while a sequence is running, produces no bus activity and leaves the status unchanged.
- R7: A status write that clears the transmit bit (bit 6) from 1 releases SDA at the next clock edge while SCL stays held.
- R8: A write to the address register releases a held SCL at the next clock edge.
- R9: With bus-busy 1, pending 0 and a new address loaded, a trigger write produces a repeated start: SDA released, then SCL released, then SDA pulled low while SCL is high, followed by the address, MSB first.
- R10: One status write that sets pending from 0 to 1 and clears master and transmit from 1 to 0 releases both SCL and SDA at the same next clock edge.
- R11: A trigger write with no address loaded since the last sequence is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | 0 selects the address register, 1 selects the status register |
| wr_data | input | 8 | Host write data |
| scl_in | input | 1 | Observed SCL line level |
| sda_in | input | 1 | Observed SDA line level |
| status | output | 8 | Status byte: master, transmit, bus-busy, pending, then four zero bits |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench models the wired-AND bus and decodes the line waveform itself, so start hold time and address bits are recovered from the wire, not from the design. Random addresses are sent through both the plain start path and the repeated-start path. This separates a correct trigger decode from one that ignores bus-busy or the pending bit. Directed cases cover a trigger with no address, a trigger on a bus owned by another master, a write to the busy bit, and the combined release write. Each of these catches a different wrong release order or a missing guard.

// File: rtl/i2cg_pkg.sv
package i2cg_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_REL_SDA, SQ_REL_SCL, SQ_START, SQ_BIT_LO, SQ_BIT_HI
  } seq_state_t;

  localparam int B_MST = 7;
  localparam int B_TRX = 6;
  localparam int B_BB  = 5;
  localparam int B_PIN = 4;
endpackage

// File: rtl/i2cg_bus_mon.sv
module i2cg_bus_mon #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic bb,
  output logic start_seen,
  output logic stop_seen
);
  logic [SYNC-1:0] scl_sy, sda_sy;
  logic scl_p, sda_p, scl_s, sda_s;

  assign scl_s = scl_sy[SYNC-1];
  assign sda_s = sda_sy[SYNC-1];
  assign start_seen = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_seen  = scl_s & scl_p & ~sda_p & sda_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
      bb     <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[SYNC-2:0], scl_in};
      sda_sy <= {sda_sy[SYNC-2:0], sda_in};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
      if (start_seen)     bb <= 1'b1;
      else if (stop_seen) bb <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cg_seq.sv
module i2cg_seq
  import i2cg_pkg::*;
#(
  parameter int HOLD = 8,
  parameter int DW   = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_start,
  input  logic          go_restart,
  input  logic [DW-1:0] addr,
  input  logic          scl_held,
  output logic          busy,
  output logic          done,
  output logic          scl_pull,
  output logic          sda_pull
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;

  seq_state_t    state;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic [DW-1:0] sh;
  logic          scl_keep;
  logic          phase_end, last_bit;

  assign phase_end = (cnt == CW'(HOLD-1));
  assign last_bit  = (bitn == BW'(DW-1));
  assign busy      = (state != SQ_IDLE);
  assign done      = (state == SQ_BIT_HI) && phase_end && last_bit;

  always_comb begin
    scl_pull = 1'b0;
    sda_pull = 1'b0;
    case (state)
      SQ_REL_SDA: scl_pull = scl_keep;
      SQ_START:   sda_pull = 1'b1;
      SQ_BIT_LO: begin scl_pull = 1'b1; sda_pull = ~sh[DW-1]; end
      SQ_BIT_HI: sda_pull = ~sh[DW-1];
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      sh       <= '0;
      scl_keep <= 1'b0;
    end else if (state == SQ_IDLE) begin
      cnt  <= '0;
      bitn <= '0;
      if (go_start) begin
        sh    <= addr;
        state <= SQ_START;
      end else if (go_restart) begin
        sh       <= addr;
        scl_keep <= scl_held;
        state    <= SQ_REL_SDA;
      end
    end else if (!phase_end) begin
      cnt <= cnt + 1'b1;
    end else begin
      cnt <= '0;
      case (state)
        SQ_REL_SDA: state <= SQ_REL_SCL;
        SQ_REL_SCL: state <= SQ_START;
        SQ_START:   state <= SQ_BIT_LO;
        SQ_BIT_LO:  state <= SQ_BIT_HI;
        SQ_BIT_HI: begin
          if (last_bit) state <= SQ_IDLE;
          else begin
            bitn  <= bitn + 1'b1;
            sh    <= {sh[DW-2:0], 1'b0};
            state <= SQ_BIT_LO;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2cg_ctrl.sv
module i2cg_ctrl
  import i2cg_pkg::*;
#(
  parameter int HOLD = 8,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic [7:0] status,
  output logic       scl_oe,
  output logic       sda_oe
);
  logic       mst, trx, pin;
  logic [7:0] addr_q;
  logic       addr_vld, scl_hold, sda_hold;
  logic       bb, start_seen, stop_seen;
  logic       seq_busy, seq_done, seq_scl, seq_sda;
  logic       wr_stat, wr_addr, trig, go_start, go_restart;

  i2cg_bus_mon #(.SYNC(SYNC)) mon_i (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .bb(bb), .start_seen(start_seen), .stop_seen(stop_seen)
  );

  assign wr_stat    = wr_en & wr_sel & ~seq_busy;
  assign wr_addr    = wr_en & ~wr_sel & ~seq_busy;
  assign trig       = wr_stat & (wr_data[7:4] == 4'hF);
  assign go_start   = trig & ~bb & addr_vld;
  assign go_restart = trig & bb & ~pin & addr_vld;

  i2cg_seq #(.HOLD(HOLD), .DW(8)) seq_i (
    .clk(clk), .rst(rst), .go_start(go_start), .go_restart(go_restart),
    .addr(addr_q), .scl_held(scl_hold), .busy(seq_busy), .done(seq_done),
    .scl_pull(seq_scl), .sda_pull(seq_sda)
  );

  assign status = {mst, trx, bb, pin, 4'b0000};
  assign scl_oe = seq_busy ? seq_scl : scl_hold;
  assign sda_oe = seq_busy ? seq_sda : sda_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      mst      <= 1'b0;
      trx      <= 1'b0;
      pin      <= 1'b1;
      addr_q   <= '0;
      addr_vld <= 1'b0;
      scl_hold <= 1'b0;
      sda_hold <= 1'b0;
    end else if (seq_done) begin
      scl_hold <= 1'b1;
      sda_hold <= 1'b1;
      pin      <= 1'b0;
    end else if (go_start | go_restart) begin
      mst      <= 1'b1;
      trx      <= 1'b1;
      pin      <= 1'b1;
      addr_vld <= 1'b0;
      scl_hold <= 1'b0;
      sda_hold <= 1'b0;
    end else if (wr_stat & ~trig) begin
      mst <= wr_data[B_MST];
      trx <= wr_data[B_TRX];
      pin <= wr_data[B_PIN];
      if (trx & ~wr_data[B_TRX]) sda_hold <= 1'b0;
      if (~pin & wr_data[B_PIN]) scl_hold <= 1'b0;
    end else if (wr_addr) begin
      addr_q   <= wr_data;
      addr_vld <= 1'b1;
      scl_hold <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cg_ctrl_chk.sv
module i2cg_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       wr_sel,
  input logic [7:0] wr_data,
  input logic [7:0] status,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       bb,
  input logic       start_seen,
  input logic       busy,
  input logic       trx,
  input logic       pin
);
  AST_RESET_RELEASED: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!scl_oe && !sda_oe)); // R1
  AST_BB_SET_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(bb) |-> $past(start_seen)); // R2
  AST_HOLD_AFTER_ADDR: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (scl_oe && sda_oe && !status[4])); // R5
  AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel && wr_data[7:4] == 4'hF && !busy && bb && pin) |=> !busy); // R6
  AST_TRX_DROP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel && !busy && wr_data[7:4] != 4'hF && trx && !wr_data[6]) |=> !sda_oe); // R7
  AST_ADDR_WR_REL: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_sel && !busy) |=> !scl_oe); // R8
  AST_DUAL_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel && !busy && wr_data[7:4] != 4'hF && !pin && wr_data[4] && trx && !wr_data[6])
    |=> (!scl_oe && !sda_oe)); // R10
endmodule

bind i2cg_ctrl i2cg_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .status(status), .scl_oe(scl_oe), .sda_oe(sda_oe), .bb(bb),
  .start_seen(start_seen), .busy(seq_busy), .trx(trx), .pin(pin)
);

// File: tb/i2cg_ctrl_test.sv
module i2cg_ctrl_test;
  localparam int HOLD = 4;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic tb_scl_pull = 1'b0, tb_sda_pull = 1'b0;
  logic [7:0] status;
  logic scl_oe, sda_oe;
  wire scl_line = ~scl_oe & ~tb_scl_pull;
  wire sda_line = ~sda_oe & ~tb_sda_pull;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  i2cg_ctrl #(.HOLD(HOLD), .SYNC(2)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .scl_in(scl_line), .sda_in(sda_line), .status(status),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  function automatic logic [7:0] exp_stat(bit m, bit t, bit b, bit p);
    return {m, t, b, p, 4'b0000};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(bit sel, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // decode a start (or repeated start) and one address byte from the wire
  task automatic capture(output logic [7:0] got, output int hold_cnt, output bit ok);
    int phase = 0, nbits = 0;
    bit ps = 1'b1, pd = 1'b1;
    got = '0; hold_cnt = 0; ok = 1'b0;
    for (int i = 0; i < 64 * HOLD; i++) begin
      if (i > 0) @(negedge clk);
      if (phase == 0 && scl_line && ps && pd && !sda_line) phase = 1;
      if (phase == 1) begin
        if (scl_line && !sda_line) hold_cnt++;
        else if (!scl_line) phase = 2;
      end else if (phase == 2) begin
        if (scl_line && !ps) begin got = {got[6:0], sda_line}; nbits++; end
        if (nbits == 8 && !scl_line) begin ok = 1'b1; break; end
      end
      ps = scl_line; pd = sda_line;
    end
  endtask

  task automatic bus_stop_external();
    tb_sda_pull = 1'b1; idle(6);
    tb_sda_pull = 1'b0; idle(6);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] a, got;
    int hc;
    bit ok;
    void'($urandom(32'd2024));
    idle(3);
    rst = 1'b0;
    idle(1);
    check("R1 status", status, exp_stat(0, 0, 0, 1));
    check("R1 lines", {scl_oe, sda_oe}, 2'b00);

    wr(1'b1, 8'h30); idle(2);
    check("R3 bb write ignored", status, exp_stat(0, 0, 0, 1));

    wr(1'b1, 8'hF0);
    for (int i = 0; i < 3 * HOLD; i++) begin
      check("R11 no addr no drive", {scl_oe, sda_oe}, 2'b00);
      @(negedge clk);
    end
    check("R11 status", status, exp_stat(0, 0, 0, 1));

    tb_sda_pull = 1'b1; idle(6);
    check("R2 external start sets bb", status, exp_stat(0, 0, 1, 1));
    wr(1'b0, 8'h5A);
    wr(1'b1, 8'hF0);
    for (int i = 0; i < 3 * HOLD; i++) begin
      check("R6 busy bus no drive", sda_oe, 1'b0);
      @(negedge clk);
    end
    check("R6 status kept", status, exp_stat(0, 0, 1, 1));
    tb_sda_pull = 1'b0; idle(6);
    check("R2 external stop clears bb", status, exp_stat(0, 0, 0, 1));

    for (int n = 0; n < 8; n++) begin
      a = 8'($urandom);
      if (n == 0) a = 8'h00;
      if (n == 1) a = 8'hFF;
      wr(1'b0, a);
      wr(1'b1, 8'hF0);
      capture(got, hc, ok);
      check("R4 start decoded", ok, 1'b1);
      check("R4 address bits", got, a);
      check("R4 start hold", (hc >= HOLD), 1'b1);
      check("R5 lines held", {scl_oe, sda_oe}, 2'b11);
      check("R5 status", status, exp_stat(1, 1, 1, 0));
      idle(2);
      wr(1'b1, 8'hF0);
      idle(2);
      check("R11 retrigger without addr", {scl_oe, sda_oe, status}, {2'b11, exp_stat(1, 1, 1, 0)});
      if (n % 2 == 0) begin
        wr(1'b1, 8'h00);
        check("R7 sda released scl held", {scl_oe, sda_oe}, 2'b10);
        check("R7 status", status, exp_stat(0, 0, 1, 0));
        a = 8'($urandom);
        wr(1'b0, a);
        check("R8 scl released", scl_oe, 1'b0);
        wr(1'b1, 8'hF0);
        capture(got, hc, ok);
        check("R9 restart decoded", ok, 1'b1);
        check("R9 restart address", got, a);
        check("R9 restart hold", (hc >= HOLD), 1'b1);
        check("R9 status", status, exp_stat(1, 1, 1, 0));
      end
      wr(1'b1, 8'h10);
      check("R10 both released together", {scl_oe, sda_oe}, 2'b00);
      check("R10 status", status, exp_stat(0, 0, 1, 1));
      bus_stop_external();
      check("R2 stop after transfer", status[5], 1'b0);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule